// File: doc/BRIEF.md
# Gate Edge Time Stamper

This block watches a set of switch-gate lines coming from an external controller. It records, with clock-cycle resolution, where inside each fixed simulation step every logic transition happened. A step counter is cleared by a step strobe and then counts clock cycles. Each line passes through a two-flop synchroniser. Whenever a synchronised line changes, the block stores the current count, the line's global index and the level the line has just taken.

The lines are split into groups of equal size, and each group has room for a fixed number of events per step. At every strobe the events gathered during the step that just ended are frozen into a readout store, and capture for the new step starts again from empty. The frozen batch then streams out one event at a time over a valid/ready handshake. The batch goes out with a per-group overflow flag and with the synchronised level of every line at the end of the step. A line that had no transitions contributes no event, so a consumer holds it at its reported level for the whole step.

Top module: `gate_edge_stamper`

## Requirements
- R1: The step count is 0 in the first cycle after a clock edge that samples `step_strobe` high. It rises by one each cycle after that and stays at STEP_COUNT-1 once it gets there. A gate line that changes in the cycle where the count is c is stamped min(c+2, STEP_COUNT-1). The +2 is the fixed synchroniser offset.
- R2: Each event carries `ev_chan` = group*LINES_PER_GROUP + line and `ev_level` = the line's level after the transition.
- R3: Within one step a group keeps at most EV_PER_GROUP events. Further events of that group are dropped, and bit g of `step_ovf` is 1 for that step's batch. A group with exactly EV_PER_GROUP events does not flag overflow.
- R4: An edge first seen in the last cycle of a step (stamp STEP_COUNT-1) belongs to that step. A line change in the last two cycles of a step, counted c cycles into a step of n cycles, is reported in the next step with stamp c+2-n.
- R5: A batch lists group 0 first and then ascending groups. Within a group, events come in detection order, and events seen in the same cycle come out by ascending line index.
- R6: While `ev_valid` is high and `ev_ready` is low, the event fields hold. `ev_last` is 1 on the final event of the batch, and after it is taken `ev_valid` falls.
- R7: `step_level` and `step_ovf` change only at a strobe. `step_level` holds the synchronised line levels at the end of the step, and this includes lines whose events were dropped.
- R8: Entries of a batch that are still unread when the next strobe arrives are discarded and replaced by the new batch. No event appears between strobes once the batch is empty.
- R9: After reset `ev_valid`, `step_ovf` and `step_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| step_strobe | input | 1 | Step boundary, one cycle wide |
| gate_in | input | GROUPS*LINES_PER_GROUP | Asynchronous gate lines |
| ev_valid | output | 1 | An event is presented |
| ev_ready | input | 1 | Consumer takes the presented event |
| ev_chan | output | clog2(GROUPS*LINES_PER_GROUP) | Global line index of the event |
| ev_level | output | 1 | Level of the line after the edge |
| ev_stamp | output | clog2(STEP_COUNT) | Count at which the edge was seen |
| ev_last | output | 1 | Presented event is the last in the batch |
| step_ovf | output | GROUPS | Per-group overflow of the presented batch |
| step_level | output | GROUPS*LINES_PER_GROUP | Line levels at the end of the presented step |

## Verification
The hardest cases to reach are at the step boundary. There the edge-to-step assignment depends on exactly which of the last three cycles a line moved in. The overflow case is hard too, because it needs a group's budget to be spent partly by edges carried over from the previous step. The stimulus counts cycles from the strobe edge and toggles lines in the last three cycles of one step. It then adds same-cycle edges in the same group in the following step, so that the carried events take slots before the new ones. A stretched step reaches the saturated count, and a step with `ev_ready` held low shows that an unread batch is discarded.

// File: rtl/gate_edge_stamper.sv
module gate_edge_stamper #(
  parameter int GROUPS          = 2,
  parameter int LINES_PER_GROUP = 6,
  parameter int STEP_COUNT      = 1000,
  parameter int EV_PER_GROUP    = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         step_strobe,
  input  logic [GROUPS*LINES_PER_GROUP-1:0]            gate_in,
  output logic                                         ev_valid,
  input  logic                                         ev_ready,
  output logic [$clog2(GROUPS*LINES_PER_GROUP)-1:0]    ev_chan,
  output logic                                         ev_level,
  output logic [$clog2(STEP_COUNT)-1:0]                ev_stamp,
  output logic                                         ev_last,
  output logic [GROUPS-1:0]                            step_ovf,
  output logic [GROUPS*LINES_PER_GROUP-1:0]            step_level
);

  localparam int NL    = GROUPS * LINES_PER_GROUP;
  localparam int CW    = $clog2(STEP_COUNT);
  localparam int CHW   = $clog2(NL);
  localparam int SLOTS = GROUPS * EV_PER_GROUP;
  localparam int SLW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int NW    = $clog2(EV_PER_GROUP + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(STEP_COUNT - 1);
  localparam logic [NW-1:0] FULL    = NW'(EV_PER_GROUP);

  logic [CW-1:0] cnt;
  logic [NL-1:0] s1, s2, prev;
  logic [1:0]    arm;
  logic [NL-1:0] edges;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (step_strobe) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      arm  <= '0;
    end else begin
      s1   <= gate_in;
      s2   <= s1;
      prev <= s2;
      if (arm != 2'b11) arm <= arm + 1'b1;
    end
  end

  assign edges = (s2 ^ prev) & {NL{&arm}};

  logic [CHW-1:0] cap_ch [SLOTS];
  logic [CW-1:0]  cap_st [SLOTS];
  logic [SLOTS-1:0] cap_lv;
  logic [NW-1:0]  cap_n  [GROUPS];
  logic [GROUPS-1:0] cap_ovf;

  logic [CHW-1:0] nx_ch [SLOTS];
  logic [CW-1:0]  nx_st [SLOTS];
  logic [SLOTS-1:0] nx_lv;
  logic [NW-1:0]  nx_n  [GROUPS];
  logic [GROUPS-1:0] nx_ovf;
  logic [SLW-1:0] slot;

  always_comb begin
    nx_ch  = cap_ch;
    nx_st  = cap_st;
    nx_lv  = cap_lv;
    nx_n   = cap_n;
    nx_ovf = cap_ovf;
    slot   = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int l = 0; l < LINES_PER_GROUP; l++) begin
        if (edges[g*LINES_PER_GROUP + l]) begin
          if (nx_n[g] == FULL) begin
            nx_ovf[g] = 1'b1;
          end else begin
            slot        = SLW'(g*EV_PER_GROUP + int'(nx_n[g]));
            nx_ch[slot] = CHW'(g*LINES_PER_GROUP + l);
            nx_st[slot] = cnt;
            nx_lv[slot] = s2[g*LINES_PER_GROUP + l];
            nx_n[g]     = nx_n[g] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    cap_ch <= nx_ch;
    cap_st <= nx_st;
    cap_lv <= nx_lv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || step_strobe) begin
      for (int g = 0; g < GROUPS; g++) cap_n[g] <= '0;
      cap_ovf <= '0;
    end else begin
      cap_n   <= nx_n;
      cap_ovf <= nx_ovf;
    end
  end

  logic [CHW-1:0]   rd_ch [SLOTS];
  logic [CW-1:0]    rd_st [SLOTS];
  logic [SLOTS-1:0] rd_lv;
  logic [SLOTS-1:0] rd_vld;
  logic [SLW-1:0]   sel;

  always_comb begin
    sel = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (rd_vld[i]) sel = SLW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld     <= '0;
      step_ovf   <= '0;
      step_level <= '0;
    end else if (step_strobe) begin
      for (int g = 0; g < GROUPS; g++)
        for (int s = 0; s < EV_PER_GROUP; s++)
          rd_vld[g*EV_PER_GROUP + s] <= (NW'(s) < nx_n[g]);
      step_ovf   <= nx_ovf;
      step_level <= s2;
    end else if (ev_valid && ev_ready) begin
      rd_vld[sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (step_strobe) begin
      rd_ch <= nx_ch;
      rd_st <= nx_st;
      rd_lv <= nx_lv;
    end
  end

  assign ev_valid = |rd_vld;
  assign ev_last  = ($countones(rd_vld) == 1);
  assign ev_chan  = rd_ch[sel];
  assign ev_stamp = rd_st[sel];
  assign ev_level = rd_lv[sel];

endmodule

// File: rtl/gate_edge_stamper_chk.sv
module gate_edge_stamper_chk #(
  parameter int NL         = 12,
  parameter int CHW        = 4,
  parameter int CW         = 10,
  parameter int GROUPS     = 2,
  parameter int STEP_COUNT = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_strobe,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [CHW-1:0]    ev_chan,
  input logic              ev_level,
  input logic [CW-1:0]     ev_stamp,
  input logic              ev_last,
  input logic [GROUPS-1:0] step_ovf,
  input logic [NL-1:0]     step_level
);

  assert_stamp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_stamp <= CW'(STEP_COUNT - 1));

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> int'(ev_chan) < NL);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready && !step_strobe) |=>
      (ev_valid && $stable(ev_chan) && $stable(ev_level) && $stable(ev_stamp)));

  assert_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_last && !step_strobe) |=> !ev_valid);

  assert_no_spawn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !step_strobe) |=> !ev_valid);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_strobe |=> ($stable(step_level) && $stable(step_ovf)));

endmodule

bind gate_edge_stamper gate_edge_stamper_chk #(
  .NL(NL), .CHW(CHW), .CW(CW), .GROUPS(GROUPS), .STEP_COUNT(STEP_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
  .ev_level(ev_level), .ev_stamp(ev_stamp), .ev_last(ev_last),
  .step_ovf(step_ovf), .step_level(step_level)
);

// File: tb/gate_edge_stamper_test.sv
module gate_edge_stamper_test;
  localparam int G = 2, LPG = 6, L = 1000, E = 4, NL = G * LPG;

  logic clk = 0, rst_n = 0, step_strobe = 0, ev_ready = 0;
  logic [NL-1:0] gate = '0;
  logic ev_valid, ev_level, ev_last;
  logic [3:0] ev_chan;
  logic [9:0] ev_stamp;
  logic [G-1:0] step_ovf;
  logic [NL-1:0] step_level;

  always #10 clk = ~clk;

  gate_edge_stamper uut (
    .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe), .gate_in(gate),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
    .ev_level(ev_level), .ev_stamp(ev_stamp), .ev_last(ev_last),
    .step_ovf(step_ovf), .step_level(step_level));

  typedef struct { int g; int ch; int lv; int st; } ev_t;
  ev_t expq[$], pend[$], carry[$];
  int tj[$], tl[$];
  int checks = 0, errors = 0;
  logic [G-1:0] exp_ovf = '0;
  logic [NL-1:0] exp_lv = '0, snap = '0;
  bit hold_v = 0;
  int hold_ch, hold_lv, hold_st;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tog(input int j, input int line);
    tj.push_back(j);
    tl.push_back(line);
  endtask

  // monitor: pops the scoreboard when a transfer is offered at this cycle
  task automatic mon();
    ev_t e;
    if (hold_v && ev_valid) begin
      chk(int'(ev_chan) == hold_ch && int'(ev_level) == hold_lv && int'(ev_stamp) == hold_st,
          "R6 fields held under backpressure", int'(ev_stamp), hold_st);
    end
    hold_v = ev_valid && !ev_ready;
    hold_ch = int'(ev_chan); hold_lv = int'(ev_level); hold_st = int'(ev_stamp);
    if (ev_valid && ev_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected event chan", int'(ev_chan), -1);
      end else begin
        e = expq.pop_front();
        chk(int'(ev_chan) == e.ch, "R2/R5 chan", int'(ev_chan), e.ch);
        chk(int'(ev_level) == e.lv, "R2 level", int'(ev_level), e.lv);
        chk(int'(ev_stamp) == e.st, "R1/R4 stamp", int'(ev_stamp), e.st);
        chk(ev_last == (expq.size() == 0), "R6 last", int'(ev_last), int'(expq.size() == 0));
      end
    end
  endtask

  // driver: runs one step of len cycles, then strobes and builds the expected batch
  task automatic do_step(input int mode, input int len);
    for (int j = 0; j < len; j++) begin
      if (j == len - 1) begin
        ev_ready = 0;
        step_strobe = 1;
      end else begin
        ev_ready = (mode == 0) || (mode == 1 && (j % 2 == 0));
        mon();
      end
      for (int k = 0; k < tj.size(); k++) begin
        if (tj[k] == j) begin
          ev_t e;
          gate[tl[k]] = ~gate[tl[k]];
          e.g = tl[k] / LPG; e.ch = tl[k]; e.lv = int'(gate[tl[k]]);
          if (j + 2 <= len - 1) begin
            e.st = (j + 2 > L - 1) ? L - 1 : j + 2;
            pend.push_back(e);
          end else begin
            e.st = j + 2 - len;
            carry.push_back(e);
          end
        end
      end
      if (j == len - 3) snap = gate;
      if (j < len - 1) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    if (mode != 2) chk(expq.size() == 0, "R6 batch drained", expq.size(), 0);
    expq.delete();
    exp_ovf = '0;
    for (int g = 0; g < G; g++) begin
      int n = 0;
      foreach (pend[k]) begin
        if (pend[k].g == g) begin
          if (n < E) begin expq.push_back(pend[k]); n++; end
          else exp_ovf[g] = 1'b1;
        end
      end
    end
    pend = carry;
    carry.delete();
    tj.delete(); tl.delete();
    exp_lv = snap;
    hold_v = 0;
    @(posedge clk);
    @(negedge clk);
    step_strobe = 0;
    chk(step_ovf == exp_ovf, "R3 overflow flags", int'(step_ovf), int'(exp_ovf));
    chk(step_level == exp_lv, "R7 step levels", int'(step_level), int'(exp_lv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(ev_valid == 0, "R9 valid after reset", int'(ev_valid), 0);
    chk(step_ovf == 0, "R9 overflow after reset", int'(step_ovf), 0);
    chk(step_level == 0, "R9 levels after reset", int'(step_level), 0);
    repeat (3) @(negedge clk);
    step_strobe = 1;
    @(posedge clk);
    @(negedge clk);
    step_strobe = 0;

    // quiet step: empty batch, R7 no event for steady lines
    do_step(0, L);
    // R1 R2 R5: stamps j+2, groups ordered, example count 625
    tog(0, 7); tog(100, 7); tog(623, 0);
    do_step(0, L);
    // R4: last-cycle edge stays, last two cycles carry into the next step
    tog(L - 3, 3); tog(L - 2, 4); tog(L - 1, 5);
    do_step(0, L);
    // R3: group 0 gets carried events plus three more -> one dropped; group 1 exactly full
    tog(10, 1); tog(10, 2); tog(20, 0);
    tog(50, 6); tog(50, 8); tog(50, 9); tog(50, 11);
    do_step(0, L);
    // R6: alternating ready while draining; R5 same cycle across groups
    tog(5, 0); tog(5, 6); tog(6, 11); tog(500, 2);
    do_step(1, L);
    // R8: ready held low, previous batch must be discarded
    tog(300, 10);
    do_step(2, L);
    chk(ev_valid && ev_chan == 4'd10, "R8 new batch replaces unread one", int'(ev_chan), 10);
    do_step(0, L);
    // R7: no edges, levels kept, flags clear
    do_step(0, L);
    // R1: stretched step, count saturates at STEP_COUNT-1
    tog(L + 5, 1); tog(3, 9);
    do_step(0, L + 20);
    do_step(0, L);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule